// File: doc/BRIEF.md
# DMA Event Collector and Interrupt Aggregator

This block gathers the per-channel event pulses of a multi-channel DMA engine and turns them into software-visible state and one interrupt line. Each channel, up to 32 of them, can report four kinds of event: a finished segment, a fault on the read side, a fault on the write side and a bad channel setup. Every kind has its own sticky raw register, with one bit per channel. Software acknowledges an event by writing a 1 to that bit of the raw register. A filtered view of each raw register is also readable. It keeps only the channels whose interrupt enable is on.

A finished segment is recorded only when both of its two interrupt-enable bits are set. These are the segment control word's bits 5:4, which the channel presents beside its done pulse. The block also shows which channels are busy, and it holds two words of arbitration settings as plain storage. The interrupt output is high whenever any filtered bit of any kind is set.

Access is through a simple 32-bit bus. The read data is combinational and follows the address in the same cycle. A write takes effect at the next rising clock edge.

Top module: `dmairq_ctrl`

## Requirements
- R1: After reset every raw register, the priority word and the arbitration word read as zero, and `irq_o` is low.
- R2: A pulse on `seg_done[n]` sets bit n of the raw completion register (offset 0x810) only when `seg_irq_en[2n+1:2n]` is 2'b11 in the same cycle. With 2'b00, 2'b01 or 2'b10 the pulse has no effect.
- R3: Pulses on `src_err[n]`, `dst_err[n]` and `cfg_err[n]` set bit n of the raw registers at 0x814, 0x818 and 0x81C respectively, one clock after the pulse.
- R4: Writing a raw register clears each bit whose write data is 1 and leaves every bit whose write data is 0. Writing 0xFFFFFFFF clears all channels.
- R5: If an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R6: The filtered registers at 0x800, 0x804, 0x808 and 0x80C read as the matching raw register ANDed with `chan_irq_en`.
- R7: `irq_o` is the OR of all filtered bits of all four event kinds. It is low when no raw bit of an enabled channel is set.
- R8: Offset 0x820 reads `chan_busy`, with bit n for channel n.
- R9: Offsets 0x824 (group priority) and 0x828 (arbitration) store all 32 written bits and read them back. Writing 0 to arbitration reads back 0, which selects equal priority.
- R10: Writes to the filtered registers or to 0x820 change no state. Unmapped offsets read as zero.
- R11: A raw bit that has been set stays set through any number of idle cycles until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| seg_done | input | NCH | Segment-finished pulse per channel |
| seg_irq_en | input | 2*NCH | Segment control bits 5:4 per channel, channel n at [2n+1:2n] |
| src_err | input | NCH | Read-side fault pulse per channel |
| dst_err | input | NCH | Write-side fault pulse per channel |
| cfg_err | input | NCH | Setup fault pulse per channel |
| chan_irq_en | input | NCH | Per-channel interrupt enable |
| chan_busy | input | NCH | Per-channel busy flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check, on every cycle and for every event kind, four rules: a pulse always leaves its bit set (R5); a clear write drops every targeted bit that has no simultaneous pulse (R4); raw state holds when nothing touches it (R11); and a new completion bit appears only after a qualified done pulse (R2). They also check that the interrupt is silent with no raw bits and needs at least one enabled channel (R6, R7). The exact read-back values of the filtered and busy views, the priority storage and the effect of writes to read-only or unmapped offsets can only be shown by the bench's scripted register accesses.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int NUM_EVT = 4;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;

  typedef enum logic [1:0] {
    EVT_DONE = 2'd0,
    EVT_SERR = 2'd1,
    EVT_DERR = 2'd2,
    EVT_CERR = 2'd3
  } evt_kind_e;

  localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h800;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h810;
  localparam logic [ADDR_W-1:0] OFS_BUSY   = 12'h820;
  localparam logic [ADDR_W-1:0] OFS_PRIO   = 12'h824;
  localparam logic [ADDR_W-1:0] OFS_ARB    = 12'h828;

  function automatic logic [ADDR_W-1:0] raw_ofs(input int k);
    return OFS_RAW + ADDR_W'(4 * k);
  endfunction

  function automatic logic [ADDR_W-1:0] masked_ofs(input int k);
    return OFS_MASKED + ADDR_W'(4 * k);
  endfunction

  // a completion counts only when both enable bits of its segment are set
  function automatic logic done_qualifies(input logic pulse, input logic [1:0] ie);
    return pulse & (ie == 2'b11);
  endfunction

  // sticky bit update: a new event beats a clear on the same bit
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/dmairq_evt_bank.sv
module dmairq_evt_bank #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] raw_o
);
  import dmairq_pkg::*;

  for (genvar n = 0; n < NCH; n++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_o[n] <= 1'b0;
      else        raw_o[n] <= sticky_next(raw_o[n], set_i[n], clr_i[n]);
    end
  end
endmodule

// File: rtl/dmairq_decode.sv
module dmairq_decode (
  input  logic                                          bus_en,
  input  logic                                          bus_we,
  input  logic [dmairq_pkg::ADDR_W-1:0]                 bus_addr,
  output logic [dmairq_pkg::NUM_EVT-1:0]                raw_wr,
  output logic                                          prio_wr,
  output logic                                          arb_wr
);
  import dmairq_pkg::*;

  logic wr_strobe;
  assign wr_strobe = bus_en & bus_we;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_raw
    assign raw_wr[k] = wr_strobe & (bus_addr == raw_ofs(k));
  end

  assign prio_wr = wr_strobe & (bus_addr == OFS_PRIO);
  assign arb_wr  = wr_strobe & (bus_addr == OFS_ARB);
endmodule

// File: rtl/dmairq_rdmux.sv
module dmairq_rdmux #(
  parameter int NCH = 32
) (
  input  logic [dmairq_pkg::ADDR_W-1:0]            bus_addr,
  input  logic [dmairq_pkg::NUM_EVT-1:0][NCH-1:0]  raw_q,
  input  logic [dmairq_pkg::NUM_EVT-1:0][NCH-1:0]  masked,
  input  logic [NCH-1:0]                           busy,
  input  logic [dmairq_pkg::DATA_W-1:0]            prio_q,
  input  logic [dmairq_pkg::DATA_W-1:0]            arb_q,
  output logic [dmairq_pkg::DATA_W-1:0]            rdata
);
  import dmairq_pkg::*;

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (bus_addr == raw_ofs(k))    rdata = DATA_W'(raw_q[k]);
      if (bus_addr == masked_ofs(k)) rdata = DATA_W'(masked[k]);
    end
    if (bus_addr == OFS_BUSY) rdata = DATA_W'(busy);
    if (bus_addr == OFS_PRIO) rdata = prio_q;
    if (bus_addr == OFS_ARB)  rdata = arb_q;
  end
endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl #(
  parameter int NCH = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_en,
  input  logic                              bus_we,
  input  logic [dmairq_pkg::ADDR_W-1:0]     bus_addr,
  input  logic [dmairq_pkg::DATA_W-1:0]     bus_wdata,
  output logic [dmairq_pkg::DATA_W-1:0]     bus_rdata,
  input  logic [NCH-1:0]                    seg_done,
  input  logic [2*NCH-1:0]                  seg_irq_en,
  input  logic [NCH-1:0]                    src_err,
  input  logic [NCH-1:0]                    dst_err,
  input  logic [NCH-1:0]                    cfg_err,
  input  logic [NCH-1:0]                    chan_irq_en,
  input  logic [NCH-1:0]                    chan_busy,
  output logic                              irq_o
);
  import dmairq_pkg::*;

  // named internal events, visible to the bound checker
  logic [NUM_EVT-1:0][NCH-1:0] evt_set;
  logic [NUM_EVT-1:0][NCH-1:0] evt_clr;
  logic [NUM_EVT-1:0][NCH-1:0] raw_q;
  logic [NUM_EVT-1:0][NCH-1:0] masked;
  logic [NUM_EVT-1:0]          raw_wr;
  logic                        prio_wr;
  logic                        arb_wr;
  logic [DATA_W-1:0]           prio_q;
  logic [DATA_W-1:0]           arb_q;

  for (genvar n = 0; n < NCH; n++) begin : g_done
    assign evt_set[EVT_DONE][n] = done_qualifies(seg_done[n], seg_irq_en[2*n +: 2]);
  end
  assign evt_set[EVT_SERR] = src_err;
  assign evt_set[EVT_DERR] = dst_err;
  assign evt_set[EVT_CERR] = cfg_err;

  dmairq_decode u_dec (
    .bus_en  (bus_en),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .raw_wr  (raw_wr),
    .prio_wr (prio_wr),
    .arb_wr  (arb_wr)
  );

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_bank
    assign evt_clr[k] = raw_wr[k] ? bus_wdata[NCH-1:0] : '0;
    assign masked[k]  = raw_q[k] & chan_irq_en;

    dmairq_evt_bank #(.NCH(NCH)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(evt_set[k]),
      .clr_i(evt_clr[k]),
      .raw_o(raw_q[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      arb_q  <= '0;
    end else begin
      if (prio_wr) prio_q <= bus_wdata;
      if (arb_wr)  arb_q  <= bus_wdata;
    end
  end

  dmairq_rdmux #(.NCH(NCH)) u_rd (
    .bus_addr(bus_addr),
    .raw_q   (raw_q),
    .masked  (masked),
    .busy    (chan_busy),
    .prio_q  (prio_q),
    .arb_q   (arb_q),
    .rdata   (bus_rdata)
  );

  assign irq_o = |masked;
endmodule

// File: rtl/dmairq_ctrl_chk.sv
module dmairq_ctrl_chk #(
  parameter int NCH = 32
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic [dmairq_pkg::DATA_W-1:0]            bus_wdata,
  input logic [NCH-1:0]                           seg_done,
  input logic [2*NCH-1:0]                         seg_irq_en,
  input logic [NCH-1:0]                           chan_irq_en,
  input logic [dmairq_pkg::NUM_EVT-1:0]           raw_wr,
  input logic [dmairq_pkg::NUM_EVT-1:0][NCH-1:0]  evt_set,
  input logic [dmairq_pkg::NUM_EVT-1:0][NCH-1:0]  raw_q,
  input logic                                     irq_o
);
  import dmairq_pkg::*;

  logic [NCH-1:0] done_ok;
  always_comb begin
    for (int n = 0; n < NCH; n++)
      done_ok[n] = seg_done[n] && seg_irq_en[2*n+1] && seg_irq_en[2*n];
  end

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_cls
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_set[k] != '0) |=> ((raw_q[k] & $past(evt_set[k])) == $past(evt_set[k]))); // R5
    AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      raw_wr[k] |=> ((raw_q[k] & $past(bus_wdata[NCH-1:0] & ~evt_set[k])) == '0)); // R4
    AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!raw_wr[k] && evt_set[k] == '0) |=> $stable(raw_q[k])); // R11
  end

  AST_DONE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q[EVT_DONE] & ~$past(raw_q[EVT_DONE]) & ~$past(done_ok)) == '0)); // R2
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q == '0) |-> !irq_o); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (chan_irq_en != '0)); // R6
endmodule

bind dmairq_ctrl dmairq_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wdata  (bus_wdata),
  .seg_done   (seg_done),
  .seg_irq_en (seg_irq_en),
  .chan_irq_en(chan_irq_en),
  .raw_wr     (raw_wr),
  .evt_set    (evt_set),
  .raw_q      (raw_q),
  .irq_o      (irq_o)
);

// File: tb/dmairq_ctrl_tb_top.sv
module dmairq_ctrl_tb_top;
  localparam int NCH = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  seg_done = '0, src_err = '0, dst_err = '0, cfg_err = '0;
  logic [2*NCH-1:0] seg_irq_en = '0;
  logic [NCH-1:0]  chan_irq_en = '0, chan_busy = '0;
  logic            irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  dmairq_ctrl #(.NCH(NCH)) dut_i (.*);

  // bench-side expectation state
  logic [31:0] m_raw [4];
  logic [31:0] m_prio = '0, m_arb = '0;

  typedef struct { logic [11:0] addr; logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t sb_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: compares every read against the queued expectation
  always @(negedge clk) begin
    if (rst_n && bus_en && !bus_we) begin
      rd_item_t it;
      if (sb_q.size() == 0) check(1'b0, "scoreboard empty", bus_rdata, 32'h0);
      else begin
        it = sb_q.pop_front();
        check(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] mask_of(input int k);
    return m_raw[k] & 32'(chan_irq_en);
  endfunction

  function automatic logic exp_irq();
    return |(mask_of(0) | mask_of(1) | mask_of(2) | mask_of(3));
  endfunction

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_en = 1; bus_we = 0; bus_addr = a;
    tick();
    bus_en = 0;
  endtask

  // write, optionally together with an event pulse on one class
  task automatic wr_evt(input logic [11:0] a, input logic [31:0] d, input bit do_wr,
                        input int k, input logic [31:0] ev, input logic [63:0] ie);
    logic [31:0] set;
    set = ev;
    bus_en = do_wr; bus_we = do_wr; bus_addr = a; bus_wdata = d;
    case (k)
      0: begin
           seg_done = ev; seg_irq_en = ie;
           for (int n = 0; n < NCH; n++) set[n] = ev[n] && ie[2*n] && ie[2*n+1];
         end
      1: src_err = ev;
      2: dst_err = ev;
      default: cfg_err = ev;
    endcase
    tick();
    bus_en = 0; bus_we = 0;
    seg_done = '0; src_err = '0; dst_err = '0; cfg_err = '0; seg_irq_en = '0;
    if (do_wr) begin
      for (int j = 0; j < 4; j++)
        if (a == 12'h810 + 12'(4*j)) m_raw[j] = m_raw[j] & ~d;
      if (a == 12'h824) m_prio = d;
      if (a == 12'h828) m_arb = d;
    end
    m_raw[k] = m_raw[k] | set;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_evt(a, d, 1'b1, 1, 32'h0, 64'h0);
  endtask

  task automatic pulse(input int k, input logic [31:0] ev, input logic [63:0] ie);
    wr_evt(12'h000, 32'h0, 1'b0, k, ev, ie);
  endtask

  task automatic read_all(input string tag);
    for (int j = 0; j < 4; j++) begin
      rd(12'h810 + 12'(4*j), m_raw[j], {tag, " raw"});
      rd(12'h800 + 12'(4*j), mask_of(j), {tag, " R6 masked"});
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < 4; j++) m_raw[j] = '0;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R1: reset state
    read_all("R1 reset");
    rd(12'h824, 32'h0, "R1 prio reset");
    rd(12'h828, 32'h0, "R1 arb reset");
    check(irq_o === 1'b0, "R1 irq reset", 32'(irq_o), 32'h0);

    // R2: completion gated by both enable bits (ch3=11, ch5=01, ch7=10, ch9=00)
    pulse(0, 32'h0000_02A8, 64'h0 | (64'h3 << 6) | (64'h1 << 10) | (64'h2 << 14));
    rd(12'h810, 32'h0000_0008, "R2 done gating");

    // R6/R7: masking and interrupt
    check(irq_o === 1'b0, "R7 irq off with no enable", 32'(irq_o), 32'h0);
    chan_irq_en = 32'h0000_0008;
    #1;
    check(irq_o === exp_irq(), "R7 irq on done", 32'(irq_o), 32'(exp_irq()));
    rd(12'h800, mask_of(0), "R6 masked done");

    // R3: error classes on distinct patterns
    pulse(1, 32'h8000_0101, 64'h0);
    pulse(2, 32'h0F00_0000, 64'h0);
    pulse(3, 32'h0000_0001, 64'h0);
    rd(12'h814, 32'h8000_0101, "R3 src err");
    rd(12'h818, 32'h0F00_0000, "R3 dst err");
    rd(12'h81C, 32'h0000_0001, "R3 cfg err");

    // R11: sticky across idle cycles
    repeat (20) tick();
    read_all("R11 sticky");

    // R4: zero write keeps, ones clear, all ones clears all
    wr(12'h814, 32'h0);
    rd(12'h814, 32'h8000_0101, "R4 zero write keeps");
    wr(12'h814, 32'h0000_0100);
    rd(12'h814, 32'h8000_0001, "R4 partial clear");
    wr(12'h814, 32'hFFFF_FFFF);
    rd(12'h814, 32'h0, "R4 all ones clear");

    // R5: pulse and clear on the same bit in the same cycle
    wr_evt(12'h818, 32'h0300_0004, 1'b1, 2, 32'h0000_0004, 64'h0);
    rd(12'h818, 32'h0C00_0004, "R5 set beats clear");

    // R7: interrupt from an error class alone
    wr(12'h810, 32'hFFFF_FFFF);
    chan_irq_en = 32'h0000_0001;
    #1;
    check(irq_o === 1'b1, "R7 irq from cfg err", 32'(irq_o), 32'h1);
    wr(12'h81C, 32'h0000_0001);
    check(irq_o === exp_irq(), "R7 irq after clear", 32'(irq_o), 32'(exp_irq()));
    chan_irq_en = 32'h0400_0000;
    #1;
    check(irq_o === 1'b1, "R7 irq from dst err", 32'(irq_o), 32'h1);
    rd(12'h808, mask_of(2), "R6 masked dst err");
    chan_irq_en = '0;
    #1;
    check(irq_o === 1'b0, "R7 irq masked off", 32'(irq_o), 32'h0);

    // R8: busy view
    chan_busy = 32'hA5A5_0F0F;
    rd(12'h820, 32'hA5A5_0F0F, "R8 busy");
    chan_busy = 32'h0000_0001;
    rd(12'h820, 32'h0000_0001, "R8 busy single");

    // R9: priority and arbitration storage
    wr(12'h824, 32'hDEAD_BEEF);
    wr(12'h828, 32'h1234_5678);
    rd(12'h824, 32'hDEAD_BEEF, "R9 prio");
    rd(12'h828, 32'h1234_5678, "R9 arb");
    wr(12'h828, 32'h0);
    rd(12'h828, 32'h0, "R9 arb equal priority");

    // R10: read-only and unmapped offsets
    wr(12'h808, 32'hFFFF_FFFF);
    wr(12'h820, 32'hFFFF_FFFF);
    wr(12'h700, 32'hFFFF_FFFF);
    chan_irq_en = 32'hFFFF_FFFF;
    read_all("R10 no effect");
    rd(12'h824, m_prio, "R10 prio untouched");
    rd(12'h700, 32'h0, "R10 unmapped read");
    rd(12'h82C, 32'h0, "R10 unmapped read high");

    tick();
    check(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule